// File: doc/BRIEF.md
# Array Node Boot and Configuration Loader

Each node of a processor array contains a small fixed controller that owns the node between reset and program start. While it owns the node, the core is held with its instruction pointer at address 0 and does not execute. The controller listens on all of the node's ordinary input data channels for a synchronisation word. The first channel to present that word becomes the boot channel, and the controller reads a stream of command words from it.

Each command either stores program words into the node's local instruction memory or passes a block of words through to the left or right neighbour. In this way a whole row of nodes is configured from one end, with no dedicated configuration bus. A run command releases the core. A debug-halt command leaves the core stopped and hands the channels back to scanning. An unrecognised command flags an error and also returns to scanning.

Top module: `nbl_node_loader`

## Requirements
- R1: After reset, `core_run` is 0, `status` is 0 (scanning), every bit of `in_ready` is 1, and `imem_we`, `left_valid` and `right_valid` are 0.
- R2: While scanning, any word other than the sync word 16'hB007 is consumed and dropped. It causes no memory write, no forwarded word and no status change.
- R3: A valid 16'hB007 on a channel locks that channel and sets `status` to 1 (loading) from the next cycle. When several channels present it in the same cycle, the lowest-numbered channel wins.
- R4: A command word carries its opcode in bits [15:12] and a payload count in bits [11:0]. The opcodes are 1 write-memory, 2 write-left, 3 write-right, 4 run and 5 debug-halt.
- R5: For write-memory, the first payload word's bits [11:0] give a start address. Each later payload word is written to the next address, and the address wraps from 12'hFFF to 0. The count includes the address word.
- R6: For write-left and write-right, each payload word appears unchanged on the chosen neighbour output, with valid raised. The boot channel's ready follows that neighbour's ready, so a stalled neighbour stalls the input.
- R7: Run sets `core_run` to 1 and `status` to 2 (running). From then until reset, `in_ready` stays 0.
- R8: Debug-halt sets `status` to 4 (debug), keeps `core_run` at 0, and returns every channel to scanning.
- R9: Any opcode other than 1 to 5 sets `status` to 3 (error) and returns every channel to scanning.
- R10: A write-memory, write-left or write-right command with count 0 has no effect, and the next word is read as a command.
- R11: While a channel is locked, every other channel's `in_ready` is 0, and words offered on those channels are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | NUM_CH*DW | Input channel words, channel k at bits [k*DW +: DW] |
| in_valid | input | NUM_CH | Per-channel word valid |
| in_ready | output | NUM_CH | Per-channel word accepted |
| left_data | output | DW | Word forwarded to the left neighbour |
| left_valid | output | 1 | Left forward word valid |
| left_ready | input | 1 | Left neighbour can take a word |
| right_data | output | DW | Word forwarded to the right neighbour |
| right_valid | output | 1 | Right forward word valid |
| right_ready | input | 1 | Right neighbour can take a word |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | AW | Instruction memory write address |
| imem_wdata | output | DW | Instruction memory write data |
| core_run | output | 1 | Core released; while 0 the instruction pointer is held at 0 |
| status | output | 3 | 0 scanning, 1 loading, 2 running, 3 error, 4 debug |

## Verification
The bench first offers stray words, including a near-miss of the sync word, to show that scanning ignores everything else. It then drives boot frames on several channels. One frame writes a block of memory. Another writes a block that wraps past the top address, which separates a correct address increment from one that saturates or restarts. Forwarding is tried once with the neighbour always ready and once with the neighbour stalled, which tells true pass-through apart from a design that drops or repeats words. Two simultaneous sync words check the channel priority and the blocking of other channels. Zero-count, unknown, debug and run commands each end a frame differently, and each ending has its own status code and channel state to observe.

// File: rtl/nbl_pkg.sv
// Shared types for the node boot loader.
// Assumes 16-bit command words with a 4-bit opcode field at the top.
package nbl_pkg;
    typedef enum logic [2:0] {
        ST_SCAN = 3'd0,
        ST_LOAD = 3'd1,
        ST_RUN  = 3'd2,
        ST_ERR  = 3'd3,
        ST_DBG  = 3'd4
    } nbl_status_e;

    typedef enum logic [2:0] {
        F_SCAN, F_CMD, F_ADDR, F_MEM, F_FWD, F_RUN
    } nbl_fsm_e;

    localparam int OPW = 4;
    localparam logic [OPW-1:0] OP_MEM   = 4'd1;
    localparam logic [OPW-1:0] OP_LEFT  = 4'd2;
    localparam logic [OPW-1:0] OP_RIGHT = 4'd3;
    localparam logic [OPW-1:0] OP_RUN   = 4'd4;
    localparam logic [OPW-1:0] OP_DBG   = 4'd5;
endpackage

// File: rtl/nbl_sync_detect.sv
// Finds channels that present the sync word this cycle and picks the
// lowest-numbered one. Purely combinational; assumes NUM_CH >= 1.
module nbl_sync_detect #(
    parameter int NUM_CH = 4,
    parameter int DW = 16,
    parameter int IW = 2,
    parameter logic [DW-1:0] SYNC = 16'hB007
) (
    input  logic [NUM_CH*DW-1:0] in_data,
    input  logic [NUM_CH-1:0]    in_valid,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);
    logic [NUM_CH-1:0] match;

    // Per-channel comparison against the sync word.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
        assign match[k] = in_valid[k] && (in_data[k*DW +: DW] == SYNC);
    end

    // Fixed priority: the lowest index is scanned last and so wins.
    always_comb begin
        hit_idx = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (match[k]) hit_idx = IW'(k);
        end
        hit = |match;
    end
endmodule

// File: rtl/nbl_chan_mux.sv
// Selects the locked channel's word and routes ready back to it.
// While scanning all channels are drained; otherwise only the locked one
// may see ready.
module nbl_chan_mux #(
    parameter int NUM_CH = 4,
    parameter int DW = 16,
    parameter int IW = 2
) (
    input  logic [NUM_CH*DW-1:0] in_data,
    input  logic [NUM_CH-1:0]    in_valid,
    input  logic [IW-1:0]        sel_idx,
    input  logic                 scan_all,
    input  logic                 lock_en,
    input  logic                 sel_ready,
    output logic [NUM_CH-1:0]    in_ready,
    output logic [DW-1:0]        sel_data,
    output logic                 sel_valid
);
    // Ready fan-out: everything while scanning, the locked channel otherwise.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_rdy
        assign in_ready[k] = scan_all ||
                             (lock_en && (sel_idx == IW'(k)) && sel_ready);
    end

    // Word and valid of the locked channel.
    always_comb begin
        sel_data  = '0;
        sel_valid = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel_idx == IW'(k)) begin
                sel_data  = in_data[k*DW +: DW];
                sel_valid = lock_en && in_valid[k];
            end
        end
    end
endmodule

// File: rtl/nbl_cmd_fsm.sv
// Command interpreter: locks a boot channel, decodes command words,
// writes memory, forwards payload and releases the core.
// Assumes DW > OPW and AW <= DW.
module nbl_cmd_fsm
    import nbl_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [IW-1:0] hit_idx,
    input  logic [DW-1:0] sel_data,
    input  logic          sel_valid,
    input  logic          left_ready,
    input  logic          right_ready,
    output logic          sel_ready,
    output logic          scan_all,
    output logic          lock_en,
    output logic [IW-1:0] lock_idx,
    output logic          imem_we,
    output logic [AW-1:0] imem_addr,
    output logic          left_valid,
    output logic          right_valid,
    output logic          core_run,
    output logic [2:0]    status
);
    localparam int CW = DW - OPW;

    nbl_fsm_e       state;
    logic [CW-1:0]  rem;
    logic [AW-1:0]  addr_q;
    logic           fwd_right;
    logic           acc;
    logic [OPW-1:0] op;
    logic [CW-1:0]  cnt;

    assign op        = sel_data[DW-1 -: OPW];
    assign cnt       = sel_data[CW-1:0];
    assign imem_addr = addr_q;

    // Handshake and output strobes decoded from the current state.
    always_comb begin
        scan_all    = (state == F_SCAN);
        lock_en     = (state == F_CMD) || (state == F_ADDR) ||
                      (state == F_MEM) || (state == F_FWD);
        unique case (state)
            F_CMD, F_ADDR, F_MEM: sel_ready = 1'b1;
            F_FWD:                sel_ready = fwd_right ? right_ready : left_ready;
            default:              sel_ready = 1'b0;
        endcase
        acc         = sel_valid && sel_ready;
        imem_we     = (state == F_MEM) && sel_valid;
        left_valid  = (state == F_FWD) && !fwd_right && sel_valid;
        right_valid = (state == F_FWD) && fwd_right && sel_valid;
    end

    // Sequencer: frame lock, command decode and payload counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= F_SCAN;
            status    <= ST_SCAN;
            lock_idx  <= '0;
            rem       <= '0;
            addr_q    <= '0;
            fwd_right <= 1'b0;
            core_run  <= 1'b0;
        end else begin
            unique case (state)
                F_SCAN: if (hit) begin
                    lock_idx <= hit_idx;
                    state    <= F_CMD;
                    status   <= ST_LOAD;
                end
                F_CMD: if (acc) begin
                    rem <= cnt;
                    unique case (op)
                        OP_MEM:   state <= (cnt == '0) ? F_CMD : F_ADDR;
                        OP_LEFT, OP_RIGHT: begin
                            fwd_right <= (op == OP_RIGHT);
                            state     <= (cnt == '0) ? F_CMD : F_FWD;
                        end
                        OP_RUN: begin
                            core_run <= 1'b1;
                            status   <= ST_RUN;
                            state    <= F_RUN;
                        end
                        OP_DBG: begin
                            status <= ST_DBG;
                            state  <= F_SCAN;
                        end
                        default: begin
                            status <= ST_ERR;
                            state  <= F_SCAN;
                        end
                    endcase
                end
                F_ADDR: if (acc) begin
                    addr_q <= sel_data[AW-1:0];
                    rem    <= rem - 1'b1;
                    state  <= (rem == CW'(1)) ? F_CMD : F_MEM;
                end
                F_MEM: if (acc) begin
                    addr_q <= addr_q + 1'b1;
                    rem    <= rem - 1'b1;
                    if (rem == CW'(1)) state <= F_CMD;
                end
                F_FWD: if (acc) begin
                    rem <= rem - 1'b1;
                    if (rem == CW'(1)) state <= F_CMD;
                end
                default: state <= F_RUN;
            endcase
        end
    end
endmodule

// File: rtl/nbl_node_loader.sv
// Top of the node boot loader: sync detection, channel selection and the
// command interpreter. Payload words pass straight from the locked channel
// to memory or a neighbour, so ready is combinational from the neighbour.
module nbl_node_loader #(
    parameter int NUM_CH = 4,
    parameter int DW = 16,
    parameter int AW = 12,
    parameter logic [DW-1:0] SYNC = 16'hB007
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH*DW-1:0] in_data,
    input  logic [NUM_CH-1:0]    in_valid,
    output logic [NUM_CH-1:0]    in_ready,
    output logic [DW-1:0]        left_data,
    output logic                 left_valid,
    input  logic                 left_ready,
    output logic [DW-1:0]        right_data,
    output logic                 right_valid,
    input  logic                 right_ready,
    output logic                 imem_we,
    output logic [AW-1:0]        imem_addr,
    output logic [DW-1:0]        imem_wdata,
    output logic                 core_run,
    output logic [2:0]           status
);
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic          hit;
    logic [IW-1:0] hit_idx;
    logic [IW-1:0] lock_idx;
    logic          scan_all;
    logic          lock_en;
    logic          sel_ready;
    logic          sel_valid;
    logic [DW-1:0] sel_data;

    nbl_sync_detect #(.NUM_CH(NUM_CH), .DW(DW), .IW(IW), .SYNC(SYNC)) u_sync (
        .in_data (in_data),
        .in_valid(in_valid),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    nbl_chan_mux #(.NUM_CH(NUM_CH), .DW(DW), .IW(IW)) u_mux (
        .in_data  (in_data),
        .in_valid (in_valid),
        .sel_idx  (lock_idx),
        .scan_all (scan_all),
        .lock_en  (lock_en),
        .sel_ready(sel_ready),
        .in_ready (in_ready),
        .sel_data (sel_data),
        .sel_valid(sel_valid)
    );

    nbl_cmd_fsm #(.DW(DW), .AW(AW), .IW(IW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .sel_data   (sel_data),
        .sel_valid  (sel_valid),
        .left_ready (left_ready),
        .right_ready(right_ready),
        .sel_ready  (sel_ready),
        .scan_all   (scan_all),
        .lock_en    (lock_en),
        .lock_idx   (lock_idx),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .left_valid (left_valid),
        .right_valid(right_valid),
        .core_run   (core_run),
        .status     (status)
    );

    // Payload words go unchanged to every sink; strobes pick the one used.
    assign left_data  = sel_data;
    assign right_data = sel_data;
    assign imem_wdata = sel_data;
endmodule

// File: rtl/nbl_node_loader_chk.sv
// Protocol checker for the node boot loader, bound to the top module.
// Observes ports only.
module nbl_node_loader_chk #(
    parameter int NUM_CH = 4,
    parameter int AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] in_ready,
    input logic              left_valid,
    input logic              left_ready,
    input logic              right_valid,
    input logic              right_ready,
    input logic              imem_we,
    input logic [AW-1:0]     imem_addr,
    input logic              core_run,
    input logic [2:0]        status
);
    p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |=> core_run);

    p_run_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |-> (in_ready == '0));

    p_run_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> (status == 3'd2));

    p_one_sink_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({imem_we, left_valid, right_valid}) <= 1);

    p_fwd_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (left_valid || right_valid) |->
            ((|in_ready) == (left_valid ? left_ready : right_ready)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && $past(imem_we)) |-> (imem_addr == AW'($past(imem_addr) + 1'b1)));

    p_lock_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready) || (&in_ready));
endmodule

bind nbl_node_loader nbl_node_loader_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .left_valid (left_valid),
    .left_ready (left_ready),
    .right_valid(right_valid),
    .right_ready(right_ready),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .core_run   (core_run),
    .status     (status)
);

// File: tb/nbl_node_loader_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected memory writes and forwarded
// words; a monitor pops and compares them as the design emits them.
module nbl_node_loader_tb;
    localparam int NC = 4;
    localparam int DW = 16;
    localparam int AW = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC*DW-1:0]  in_data = '0;
    logic [NC-1:0]     in_valid = '0;
    logic [NC-1:0]     in_ready;
    logic [DW-1:0]     left_data, right_data, imem_wdata;
    logic              left_valid, right_valid, imem_we, core_run;
    logic              left_ready = 1'b1;
    logic              right_ready = 1'b1;
    logic [AW-1:0]     imem_addr;
    logic [2:0]        status;

    int checks = 0;
    int fails = 0;
    logic [AW+DW-1:0] q_mem[$];
    logic [DW-1:0]    q_left[$];
    logic [DW-1:0]    q_right[$];

    always #2.5 clk = ~clk;

    nbl_node_loader u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .left_data(left_data), .left_valid(left_valid),
        .left_ready(left_ready), .right_data(right_data), .right_valid(right_valid),
        .right_ready(right_ready), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .core_run(core_run), .status(status)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Offer one word on a channel and hold it until it is taken.
    task automatic send(input int ch, input logic [DW-1:0] w);
        logic acc;
        @(negedge clk);
        in_data[ch*DW +: DW] = w;
        in_valid[ch] = 1'b1;
        forever begin
            #1 acc = in_ready[ch];
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        #1 in_valid[ch] = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic exp_mem(input logic [AW-1:0] a, input logic [DW-1:0] d);
        q_mem.push_back({a, d});
    endtask

    // Monitor: compares every emitted item with the head of its queue.
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (imem_we) begin
                if (q_mem.size() == 0)
                    chk(1'b0, "R5 unexpected write", {imem_addr, imem_wdata}, 0);
                else begin
                    logic [AW+DW-1:0] e;
                    e = q_mem.pop_front();
                    chk({imem_addr, imem_wdata} == e, "R5 memory write",
                        {imem_addr, imem_wdata}, e);
                end
            end
            if (left_valid && left_ready) begin
                if (q_left.size() == 0) chk(1'b0, "R6 unexpected left word", left_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = q_left.pop_front();
                    chk(left_data == e, "R6 left word", left_data, e);
                end
            end
            if (right_valid && right_ready) begin
                if (q_right.size() == 0) chk(1'b0, "R6 unexpected right word", right_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = q_right.pop_front();
                    chk(right_data == e, "R6 right word", right_data, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hang expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        // R1 reset state
        chk(status == 3'd0 && !core_run, "R1 status/run", {status, core_run}, 0);
        chk(in_ready == 4'hF, "R1 ready", in_ready, 4'hF);
        chk(!imem_we && !left_valid && !right_valid, "R1 strobes",
            {imem_we, left_valid, right_valid}, 0);

        // R2 stray words while scanning are dropped
        send(0, 16'h1234);
        send(0, 16'hB006);
        send(3, 16'h1001);
        settle();
        chk(status == 3'd0, "R2 status unchanged", status, 0);
        chk(in_ready == 4'hF, "R2 still scanning", in_ready, 4'hF);

        // R3 lock on channel 2
        send(2, 16'hB007);
        settle();
        chk(status == 3'd1, "R3 loading", status, 1);
        chk(in_ready == 4'b0100, "R3 R11 only ch2 ready", in_ready, 4'b0100);

        // R4 R5 memory block at 0x010
        exp_mem(12'h010, 16'hA001);
        exp_mem(12'h011, 16'hA002);
        exp_mem(12'h012, 16'hA003);
        send(2, 16'h1004);
        send(2, 16'h0010);
        send(2, 16'hA001);
        send(2, 16'hA002);
        send(2, 16'hA003);

        // R10 zero-count forward, then the next word is a command
        send(2, 16'h2000);
        settle();
        chk(!left_valid && status == 3'd1, "R10 zero count no effect",
            {left_valid, status}, 1);

        // R6 left forwarding, neighbour ready
        q_left.push_back(16'h5A01);
        q_left.push_back(16'h5A02);
        send(2, 16'h2002);
        send(2, 16'h5A01);
        send(2, 16'h5A02);

        // R6 right forwarding with back-pressure
        q_right.push_back(16'hC001);
        q_right.push_back(16'hC002);
        q_right.push_back(16'hC003);
        right_ready = 1'b0;
        send(2, 16'h3003);
        fork
            begin
                send(2, 16'hC001);
                send(2, 16'hC002);
                send(2, 16'hC003);
            end
            begin
                settle();
                chk(in_ready[2] == 1'b0, "R6 stall holds input", in_ready[2], 0);
                chk(right_valid && right_data == 16'hC001, "R6 stalled word presented",
                    right_data, 16'hC001);
                repeat (2) @(negedge clk);
                right_ready = 1'b1;
            end
        join
        settle();
        chk(q_right.size() == 0 && q_left.size() == 0 && q_mem.size() == 0,
            "R5 R6 all items seen", q_right.size() + q_left.size() + q_mem.size(), 0);

        // R9 unknown opcode
        send(2, 16'h7000);
        settle();
        chk(status == 3'd3, "R9 error status", status, 3);
        chk(in_ready == 4'hF, "R9 back to scanning", in_ready, 4'hF);

        // R3 priority: channels 1 and 3 present sync together
        @(negedge clk);
        in_data[1*DW +: DW] = 16'hB007;
        in_data[3*DW +: DW] = 16'hB007;
        in_valid[1] = 1'b1;
        in_valid[3] = 1'b1;
        @(posedge clk);
        #1 in_valid = '0;
        settle();
        chk(in_ready == 4'b0010, "R3 lowest channel wins", in_ready, 4'b0010);
        chk(status == 3'd1, "R3 loading again", status, 1);

        // R11 words on another channel are not taken while locked
        in_data[3*DW +: DW] = 16'h1002;
        in_valid[3] = 1'b1;
        repeat (2) settle();
        chk(in_ready[3] == 1'b0 && !imem_we, "R11 other channel blocked",
            {in_ready[3], imem_we}, 0);
        in_valid[3] = 1'b0;

        // R8 debug-halt
        send(1, 16'h5000);
        settle();
        chk(status == 3'd4 && !core_run, "R8 debug halt", {status, core_run}, 8);
        chk(in_ready == 4'hF, "R8 channels released", in_ready, 4'hF);

        // R5 address wrap
        send(0, 16'hB007);
        exp_mem(12'hFFF, 16'hD001);
        exp_mem(12'h000, 16'hD002);
        send(0, 16'h1003);
        send(0, 16'h0FFF);
        send(0, 16'hD001);
        send(0, 16'hD002);
        settle();
        chk(q_mem.size() == 0, "R5 wrap writes seen", q_mem.size(), 0);

        // R7 run
        send(0, 16'h4000);
        settle();
        chk(core_run && status == 3'd2, "R7 running", {core_run, status}, 4'hA);
        chk(in_ready == 4'h0, "R7 channels closed", in_ready, 0);
        in_data[0 +: DW] = 16'hB007;
        in_valid[0] = 1'b1;
        repeat (3) settle();
        chk(in_ready == 4'h0 && status == 3'd2 && core_run, "R7 sync ignored after run",
            {in_ready, status, core_run}, 5);
        in_valid[0] = 1'b0;
        summary();
    end
endmodule